// File: doc/BRIEF.md
# Registered-Output Synchronous RAM Wrapper

This block wraps a small single-clock storage array and gives it a fixed, predictable timing contract. The array is clocked on the falling edge of the clock. A write presented during a cycle lands in the array at the middle of that cycle. A read address presented during a cycle is looked up at the same falling edge. The result is then moved into an output register on the following rising edge.

A consumer therefore sees a two-cycle read. It applies the read address and raises the read request in one cycle, and uses the data in the next. The data stays on the output until another read is requested. Reads and writes have separate address inputs, so one read and one write can be issued in the same cycle. Every storage element is an edge-triggered flip-flop; there are no latches.

Top module: `registered_ram_wrap`

## Requirements
- R1: While rst_ni is low, dout_o is all zeros. After reset is released, dout_o stays zero until the first read completes.
- R2: If we_i is 1 in a cycle, the word at waddr_i takes the value of wdata_i within that cycle. A read of that address requested in the very next cycle returns the new value.
- R3: If we_i is 0 in a cycle, no location changes, whatever waddr_i and wdata_i carry.
- R4: If rd_req_i is 1 with address raddr_i in cycle n, dout_o carries the word at raddr_i from the rising edge that ends cycle n. The word is available for use throughout cycle n+1.
- R5: If rd_req_i is 0 in a cycle, dout_o does not change at the rising edge that ends that cycle.
- R6: If a read and a write target the same address in the same cycle, the read returns the contents the location held before that write.
- R7: Writes on consecutive cycles to different addresses all take effect, with no idle cycle needed between them.
- R8: A read and a write to different addresses in the same cycle both complete. Each uses only its own address input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock. The array uses the falling edge and the output register uses the rising edge. |
| rst_ni | input | 1 | Active-low asynchronous reset for the read path registers. The array contents are not reset. |
| we_i | input | 1 | Write enable, active high. |
| waddr_i | input | ADDR_W | Write address. |
| wdata_i | input | DATA_W | Write data. |
| rd_req_i | input | 1 | Read request, active high. |
| raddr_i | input | ADDR_W | Read address. |
| dout_o | output | DATA_W | Registered read data. |

## Verification
The hardest case to reach is a same-cycle read and write to one address. The read must return the old word, and the bench can only tell old from new if the location already holds a known value that differs from the incoming data. The directed part of the bench first fills every location. It then issues a colliding read and write whose data is the bitwise inverse of the stored word, and follows with a plain read that must show the new word. The random phase biases the read address toward the write address so that further collisions occur alongside held outputs and back-to-back writes.

// File: rtl/ram_wrap_pkg.sv
package ram_wrap_pkg;
  function automatic int unsigned depth_of(input int unsigned addr_w);
    return 32'd1 << addr_w;
  endfunction
endpackage

// File: rtl/ram_wrap_array.sv
module ram_wrap_array
  import ram_wrap_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvld_o
);
  localparam int unsigned DEPTH = depth_of(ADDR_W);

  logic [DATA_W-1:0] mem_q [DEPTH];

  // array on inverted clock
  always_ff @(negedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read sampled at the same edge: sees pre-write contents
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      rvld_o  <= 1'b0;
    end else begin
      rvld_o <= rd_req_i;
      if (rd_req_i) rdata_o <= mem_q[raddr_i];
    end
  end
endmodule

// File: rtl/ram_wrap_out_reg.sv
module ram_wrap_out_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_o <= '0;
    else if (vld_i) data_o <= data_i;
  end
endmodule

// File: rtl/registered_ram_wrap.sv
module registered_ram_wrap #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] dout_o
);
  logic [DATA_W-1:0] arr_rdata;
  logic              arr_rvld;

  ram_wrap_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .waddr_i  (waddr_i),
    .wdata_i  (wdata_i),
    .rd_req_i (rd_req_i),
    .raddr_i  (raddr_i),
    .rdata_o  (arr_rdata),
    .rvld_o   (arr_rvld)
  );

  ram_wrap_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (arr_rvld),
    .data_i (arr_rdata),
    .data_o (dout_o)
  );
endmodule

// File: rtl/registered_ram_wrap_chk.sv
module registered_ram_wrap_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] waddr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rd_req_i,
  input logic [ADDR_W-1:0] raddr_i,
  input logic [DATA_W-1:0] dout_o
);
  always @(negedge clk_i) begin
    if (!rst_ni) assert_reset_clear_R1: assert (dout_o == '0);
  end

  assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> $stable(dout_o));

  assert_write_then_read_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && rd_req_i && raddr_i == $past(waddr_i))
    |=> dout_o == $past(wdata_i, 2));

  assert_collision_old_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i) && we_i && rd_req_i && raddr_i == waddr_i && waddr_i == $past(waddr_i))
    |=> dout_o == $past(wdata_i, 2));
endmodule

bind registered_ram_wrap registered_ram_wrap_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (we_i),
  .waddr_i  (waddr_i),
  .wdata_i  (wdata_i),
  .rd_req_i (rd_req_i),
  .raddr_i  (raddr_i),
  .dout_o   (dout_o)
);

// File: tb/registered_ram_wrap_tb.sv
`timescale 1ns/1ps
module registered_ram_wrap_tb;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 8;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] waddr = '0;
  logic [DW-1:0] wdata = '0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] raddr = '0;
  logic [DW-1:0] dout;

  int checks = 0;
  int fails = 0;
  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp_dout = '0;
  string exp_tag = "R1";

  always #4 clk = ~clk;

  registered_ram_wrap #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .rd_req_i(rd_req), .raddr_i(raddr), .dout_o(dout)
  );

  function automatic logic [DW-1:0] next_expect(input logic rq, input logic [AW-1:0] ra,
                                                input logic [DW-1:0] cur);
    return rq ? ref_mem[ra] : cur;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dout=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: check the result of the previous cycle, then drive new inputs
  task automatic step(input string tag, input logic w, input logic [AW-1:0] wa,
                      input logic [DW-1:0] wd, input logic rq, input logic [AW-1:0] ra);
    @(posedge clk); #1;
    check(exp_tag, dout, exp_dout);
    exp_dout = next_expect(rq, ra, exp_dout); // read sees pre-write contents (R6)
    exp_tag = tag;
    if (w) ref_mem[wa] = wd;
    we = w; waddr = wa; wdata = wd; rd_req = rq; raddr = ra;
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: timeout actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    void'($urandom(32'd1234));
    repeat (3) begin
      @(posedge clk); #1;
      check("R1", dout, '0);
    end
    rst_n = 1'b1;
    // R1/R7: back-to-back fills, output must stay zero
    for (int i = 0; i < DEPTH; i++) step("R7", 1'b1, AW'(i), DW'(8'h5A ^ i * 7), 1'b0, '0);
    // R4: read every location
    for (int i = 0; i < DEPTH; i++) step("R4", 1'b0, '0, '0, 1'b1, AW'(i));
    // R5: idle cycles hold the last result
    repeat (3) step("R5", 1'b0, '0, '0, 1'b0, '0);
    // R3: disabled write must leave the location intact
    step("R3", 1'b0, AW'(3), 8'hFF, 1'b0, '0);
    ref_mem[3] = ref_mem[3];
    step("R3", 1'b0, '0, '0, 1'b1, AW'(3));
    // R2: write then read the same word the next cycle
    step("R2", 1'b1, AW'(9), 8'hC3, 1'b0, '0);
    step("R2", 1'b0, '0, '0, 1'b1, AW'(9));
    // R6: collision returns the old word, the next read returns the new one
    d = ~ref_mem[5];
    step("R6", 1'b1, AW'(5), d, 1'b1, AW'(5));
    step("R6", 1'b0, '0, '0, 1'b1, AW'(5));
    // R8: independent read and write in one cycle
    step("R8", 1'b1, AW'(1), 8'h77, 1'b1, AW'(2));
    step("R8", 1'b0, '0, '0, 1'b1, AW'(1));
    // random mix
    for (int i = 0; i < 400; i++) begin
      a = AW'($urandom);
      d = DW'($urandom);
      step("R4", 1'($urandom), a, d, 1'($urandom),
           ($urandom % 3 == 0) ? a : AW'($urandom));
    end
    step("R5", 1'b0, '0, '0, 1'b0, '0);
    step("R5", 1'b0, '0, '0, 1'b0, '0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule